// File: doc/BRIEF.md
# Accumulate-Mode Padding Boundary Detector

This block sits between a descriptor walker and a hash data mover. In accumulate mode, software hands over a message that it has already padded, split across several requests. Any request may carry a list-end flag, so that flag cannot mark the end of the message. The block therefore finds the end from the padding itself. Each incoming segment adds its length to a running byte total. The block reads the segment's closing eight bytes as a big-endian bit count and turns it into a claimed message length. From that length it works out where the padding would start inside the segment. A segment is taken as final only when the byte at that position holds the 0x80 padding marker.

A segment that is not final is cached as an (address, length) pair. When a final segment arrives, the block releases every cached segment in arrival order, then the final segment trimmed to the padding start, as one message. The closing segment of that message carries a last flag. A request made with scatter-gather disabled goes straight through when the cache is empty. When the cache is not empty, such a request is checked for padding like any other. The block reads memory one byte at a time through a simple request/acknowledge port. The hash itself is computed elsewhere.

Top module: `pad_boundary_detector`

## Requirements
- R1: After reset, seg_ready is high, and out_valid, rd_req and err are all low.
- R2: Every scatter-gather segment adds its length to the running total. So does a direct segment that arrives while the cache holds at least one entry. The total is taken after that addition when the segment is checked.
- R3: The closing eight bytes of a segment (addresses addr+len-8 to addr+len-1) are read as a 64-bit bit count. The byte at the lowest address is the most significant. The claimed message length is this count shifted right by three.
- R4: A segment is final only under three conditions. It is at least 8 bytes long. The claimed length is no greater than the running total, with a difference d between 1 and len. The byte at addr+len-d equals 0x80. Any other segment is not final.
- R5: A final segment is released with its length trimmed to the pad offset len-d. The running total and the cache are then both cleared.
- R6: When the trimmed length is zero and segments are cached, no zero-length segment is emitted, and the last cached segment carries out_last. When the cache is empty, one zero-length segment with out_last is emitted.
- R7: A scatter-gather segment that is not final is appended to the cache and nothing is emitted for it.
- R8: A direct segment (seg_sg=0) that arrives while the cache is empty is emitted unchanged with out_last=1. The running total is left as it was.
- R9: A direct segment that arrives while the cache is not empty is checked as in R4. If it is final, it is released together with the cached segments. If not, it is emitted alone, untrimmed, with out_last=1, and the cache is kept.
- R10: A non-final scatter-gather segment that arrives while DEPTH entries are cached raises err for exactly one cycle. The cache and the running total are cleared, and the segment is dropped.
- R11: Cached segments leave in arrival order, followed by the trimmed final segment. Only the closing segment of a message has out_last=1, and an output held under backpressure keeps its values.
- R12: At most one memory read is outstanding: rd_req is not raised again before rd_ack returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_valid | input | 1 | Incoming segment present |
| seg_ready | output | 1 | Block can accept a segment |
| seg_addr | input | AW | Segment start byte address |
| seg_len | input | LW | Segment length in bytes |
| seg_sg | input | 1 | 1 = scatter-gather request, 0 = direct request |
| rd_req | output | 1 | One-byte memory read request |
| rd_addr | output | AW | Byte address of the read |
| rd_ack | input | 1 | Read data is valid |
| rd_data | input | 8 | Byte returned by memory |
| out_valid | output | 1 | Released segment present |
| out_ready | input | 1 | Downstream accepts the released segment |
| out_addr | output | AW | Released segment address |
| out_len | output | LW | Released segment length |
| out_last | output | 1 | Closing segment of a message |
| err | output | 1 | One-cycle pulse on cache overflow |

## Verification
The detector is driven with several patterns. A lone padded segment shows the trim arithmetic. Multi-segment messages show caching and release order. A padding-only closing segment and a marker-at-offset-zero case tell the zero-length drop apart from the single empty release. A segment whose trailer fits but whose marker byte is wrong, and a segment shorter than eight bytes, show that the length check alone does not close a message. Direct requests with the cache empty and with it occupied separate pass-through from combination and from lone release. A run of seventeen unfinished segments exercises overflow, and a final segment sent afterwards shows that the total was cleared.

// File: rtl/hpd_pkg.sv
// Package: shared types and constants for the padding boundary detector.
// Assumes: padding ends with an 8-byte big-endian bit count, and 0x80 opens the padding.
package hpd_pkg;

    localparam int          TRAIL_BYTES = 8;
    localparam logic [7:0]  PAD_MARK    = 8'h80;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TRAIL,
        ST_CHECK,
        ST_PADRD,
        ST_DECIDE,
        ST_EMIT_CACHE,
        ST_EMIT_TAIL
    } hpd_state_e;

endpackage

// File: rtl/hpd_trailer.sv
// Module: collects the trailer bytes most significant first and decides whether
// the running total leaves room for padding inside the current segment.
// Assumes: exactly TRAIL_BYTES shifts precede the use of cand/pad_off.
module hpd_trailer #(
    parameter int LW = 28,
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          shift_en,
    input  logic [7:0]    byte_in,
    input  logic [TW-1:0] total,
    input  logic [LW-1:0] seg_len,
    output logic          cand,
    output logic [LW-1:0] pad_off
);
    logic [63:0] bit_count;
    logic [63:0] claimed;
    logic [63:0] total_w;
    logic [63:0] len_w;
    logic [63:0] diff;

    // Shift register that assembles the big-endian bit count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            bit_count <= '0;
        end else if (shift_en) begin
            bit_count <= {bit_count[55:0], byte_in};
        end
    end

    // Range test on the claimed length and the derived pad offset.
    always_comb begin
        claimed = {3'b000, bit_count[63:3]};
        total_w = 64'(total);
        len_w   = 64'(seg_len);
        diff    = total_w - claimed;
        cand    = (claimed <= total_w) && (diff != 64'd0) && (diff <= len_w);
        pad_off = cand ? LW'(len_w - diff) : '0;
    end

endmodule

// File: rtl/hpd_cache.sv
// Module: ordered store of (address, length) pairs for segments that are waiting
// for their message to close. Read is a random-access mux.
// Assumes: push is ignored when full, and clr wins over push.
module hpd_cache #(
    parameter int AW    = 32,
    parameter int LW    = 28,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [LW-1:0] push_len,
    input  logic          clr,
    input  logic [IW-1:0] rd_idx,
    output logic [AW-1:0] rd_addr,
    output logic [LW-1:0] rd_len,
    output logic [CW-1:0] count,
    output logic          full
);
    logic [DEPTH-1:0][AW-1:0] addr_flat;
    logic [DEPTH-1:0][LW-1:0] len_flat;

    assign full = (count == CW'(DEPTH));

    // Occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (push && !full) begin
            count <= count + CW'(1);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [AW-1:0] e_addr;
        logic [LW-1:0] e_len;

        // Entry g captures the pair when it is the next free slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e_addr <= '0;
                e_len  <= '0;
            end else if (push && !full && !clr && (count == CW'(g))) begin
                e_addr <= push_addr;
                e_len  <= push_len;
            end
        end

        assign addr_flat[g] = e_addr;
        assign len_flat[g]  = e_len;
    end

    assign rd_addr = addr_flat[rd_idx];
    assign rd_len  = len_flat[rd_idx];

endmodule

// File: rtl/pad_boundary_detector.sv
// Module: top of the accumulate-mode padding boundary detector. Reads the trailer
// and marker of each segment through a byte port, caches unfinished segments and
// releases a whole message once its padding is found.
// Assumes: one memory read in flight, and rd_ack comes one or more cycles after rd_req.
module pad_boundary_detector
    import hpd_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LW    = 28,
    parameter int TW    = 32,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          seg_valid,
    output logic          seg_ready,
    input  logic [AW-1:0] seg_addr,
    input  logic [LW-1:0] seg_len,
    input  logic          seg_sg,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [7:0]    rd_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [AW-1:0] out_addr,
    output logic [LW-1:0] out_len,
    output logic          out_last,
    output logic          err
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    hpd_state_e    st;
    logic [AW-1:0] a_addr, tail_addr;
    logic [LW-1:0] a_len, tail_len, pad_off_r, pad_off_w;
    logic          a_sg, final_r, keep_cache, pend, err_r;
    logic [TW-1:0] total;
    logic [2:0]    byte_i;
    logic [IW-1:0] emit_idx;

    logic          c_push, c_clr, c_full;
    logic [CW-1:0] c_count;
    logic [AW-1:0] c_rd_addr;
    logic [LW-1:0] c_rd_len;
    logic          t_clr, t_shift, t_cand;
    logic          accept, out_fire, last_cached, overflow;

    assign seg_ready   = (st == ST_IDLE);
    assign accept      = seg_valid && seg_ready;
    assign out_fire    = out_valid && out_ready;
    assign last_cached = ((CW'(emit_idx) + CW'(1)) == c_count);
    assign overflow    = (st == ST_DECIDE) && !final_r && a_sg && c_full;
    assign err         = err_r;

    // Byte read request and address for the trailer and marker phases.
    always_comb begin
        rd_req  = 1'b0;
        rd_addr = a_addr + AW'(pad_off_r);
        if (st == ST_TRAIL) begin
            rd_req  = !pend;
            rd_addr = a_addr + AW'(a_len) - AW'(TRAIL_BYTES) + AW'(byte_i);
        end else if (st == ST_PADRD) begin
            rd_req  = !pend;
        end
    end

    // Output mux: cached entries first, then the held tail segment.
    always_comb begin
        out_valid = (st == ST_EMIT_CACHE) || (st == ST_EMIT_TAIL);
        out_addr  = (st == ST_EMIT_CACHE) ? c_rd_addr : tail_addr;
        out_len   = (st == ST_EMIT_CACHE) ? c_rd_len  : tail_len;
        out_last  = (st == ST_EMIT_TAIL) ||
                    ((st == ST_EMIT_CACHE) && last_cached && (tail_len == '0));
    end

    // Cache and trailer controls.
    always_comb begin
        c_push  = (st == ST_DECIDE) && !final_r && a_sg && !c_full;
        c_clr   = overflow || (out_fire && out_last && !keep_cache);
        t_clr   = accept;
        t_shift = (st == ST_TRAIL) && pend && rd_ack;
    end

    // Main sequencer: accept, read trailer, read marker, decide, emit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            a_addr     <= '0;
            a_len      <= '0;
            a_sg       <= 1'b0;
            tail_addr  <= '0;
            tail_len   <= '0;
            pad_off_r  <= '0;
            final_r    <= 1'b0;
            keep_cache <= 1'b0;
            pend       <= 1'b0;
            err_r      <= 1'b0;
            total      <= '0;
            byte_i     <= '0;
            emit_idx   <= '0;
        end else begin
            err_r <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (accept) begin
                        a_addr <= seg_addr;
                        a_len  <= seg_len;
                        a_sg   <= seg_sg;
                        byte_i <= '0;
                        pend   <= 1'b0;
                        if (!seg_sg && (c_count == '0)) begin
                            tail_addr  <= seg_addr;
                            tail_len   <= seg_len;
                            keep_cache <= 1'b1;
                            st         <= ST_EMIT_TAIL;
                        end else begin
                            total <= total + TW'(seg_len);
                            if (seg_len < LW'(TRAIL_BYTES)) begin
                                final_r <= 1'b0;
                                st      <= ST_DECIDE;
                            end else begin
                                st <= ST_TRAIL;
                            end
                        end
                    end
                end
                ST_TRAIL: begin
                    if (!pend) begin
                        pend <= 1'b1;
                    end else if (rd_ack) begin
                        pend   <= 1'b0;
                        byte_i <= byte_i + 3'd1;
                        if (byte_i == 3'd7) begin
                            st <= ST_CHECK;
                        end
                    end
                end
                ST_CHECK: begin
                    if (t_cand) begin
                        pad_off_r <= pad_off_w;
                        st        <= ST_PADRD;
                    end else begin
                        final_r <= 1'b0;
                        st      <= ST_DECIDE;
                    end
                end
                ST_PADRD: begin
                    if (!pend) begin
                        pend <= 1'b1;
                    end else if (rd_ack) begin
                        pend    <= 1'b0;
                        final_r <= (rd_data == PAD_MARK);
                        st      <= ST_DECIDE;
                    end
                end
                ST_DECIDE: begin
                    emit_idx <= '0;
                    if (final_r) begin
                        total      <= '0;
                        tail_addr  <= a_addr;
                        tail_len   <= pad_off_r;
                        keep_cache <= 1'b0;
                        st         <= (c_count != '0) ? ST_EMIT_CACHE : ST_EMIT_TAIL;
                    end else if (a_sg) begin
                        if (c_full) begin
                            err_r <= 1'b1;
                            total <= '0;
                        end
                        st <= ST_IDLE;
                    end else begin
                        tail_addr  <= a_addr;
                        tail_len   <= a_len;
                        keep_cache <= 1'b1;
                        st         <= ST_EMIT_TAIL;
                    end
                end
                ST_EMIT_CACHE: begin
                    if (out_fire) begin
                        emit_idx <= emit_idx + IW'(1);
                        if (last_cached) begin
                            st <= (tail_len == '0) ? ST_IDLE : ST_EMIT_TAIL;
                        end
                    end
                end
                ST_EMIT_TAIL: begin
                    if (out_fire) begin
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    hpd_trailer #(.LW(LW), .TW(TW)) u_trailer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (t_clr),
        .shift_en (t_shift),
        .byte_in  (rd_data),
        .total    (total),
        .seg_len  (a_len),
        .cand     (t_cand),
        .pad_off  (pad_off_w)
    );

    hpd_cache #(.AW(AW), .LW(LW), .DEPTH(DEPTH)) u_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (c_push),
        .push_addr (a_addr),
        .push_len  (a_len),
        .clr       (c_clr),
        .rd_idx    (emit_idx),
        .rd_addr   (c_rd_addr),
        .rd_len    (c_rd_len),
        .count     (c_count),
        .full      (c_full)
    );

endmodule

// File: rtl/hpd_checker.sv
// Module: protocol properties of the padding boundary detector, bound to its top.
// Assumes: only top-level ports are observed.
module hpd_checker #(
    parameter int AW = 32,
    parameter int LW = 28
) (
    input logic          clk,
    input logic          rst_n,
    input logic          seg_ready,
    input logic          rd_req,
    input logic          out_valid,
    input logic          out_ready,
    input logic [AW-1:0] out_addr,
    input logic [LW-1:0] out_len,
    input logic          out_last,
    input logic          err
);
    // R1: while waiting for a segment nothing is read and nothing is offered.
    p_ready_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        seg_ready |-> (!rd_req && !out_valid));

    // R12: a read request is never issued in two consecutive cycles.
    p_one_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R11: a stalled output keeps its content.
    p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) &&
                                       $stable(out_len) && $stable(out_last)));

    // R10: the overflow flag is a single-cycle pulse.
    p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    // R10: an overflow emits nothing and leaves the block ready for the next segment.
    p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (seg_ready && !out_valid));

endmodule

bind pad_boundary_detector hpd_checker #(.AW(AW), .LW(LW)) u_hpd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .seg_ready (seg_ready),
    .rd_req    (rd_req),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr),
    .out_len   (out_len),
    .out_last  (out_last),
    .err       (err)
);

// File: tb/pad_boundary_detector_bench.sv
`timescale 1ns/1ps
module pad_boundary_detector_bench;
    localparam int AW    = 32;
    localparam int LW    = 28;
    localparam int DEPTH = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          seg_valid = 1'b0;
    logic          seg_ready;
    logic [AW-1:0] seg_addr = '0;
    logic [LW-1:0] seg_len = '0;
    logic          seg_sg = 1'b0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_ack = 1'b0;
    logic [7:0]    rd_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [AW-1:0] out_addr;
    logic [LW-1:0] out_len;
    logic          out_last;
    logic          err;

    logic [7:0] mem [0:8191];

    typedef struct {
        int    addr;
        int    len;
        bit    last;
        string req;
    } xfer_t;

    xfer_t       expq[$];
    int          cq_addr[$];
    int          cq_len[$];
    logic [63:0] tot_m;
    int          checks = 0;
    int          errors = 0;
    int          err_seen = 0;
    int          err_exp = 0;
    int          cyc = 0;

    always #2.5 clk = ~clk;

    pad_boundary_detector #(.AW(AW), .LW(LW), .TW(32), .DEPTH(DEPTH)) u_pad_boundary_detector (
        .clk(clk), .rst_n(rst_n),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
        .seg_len(seg_len), .seg_sg(seg_sg),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_len(out_len), .out_last(out_last), .err(err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Memory responder: one-cycle byte read latency.
    initial begin
        forever begin
            @(posedge clk);
            rd_ack  <= rd_req && rst_n;
            rd_data <= mem[rd_addr[12:0]];
        end
    end

    // Backpressure pattern plus per-clock comparison against the model queue.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            out_ready = ((cyc % 3) != 2);
            #1;
            if (rst_n) begin
                if (err) err_seen++;
                if (out_valid && out_ready) begin
                    if (expq.size() == 0) begin
                        chk(1'b0, "R11", "unexpected output addr", longint'(out_addr), -1);
                    end else begin
                        xfer_t e;
                        e = expq.pop_front();
                        chk(out_addr == AW'(e.addr), e.req, "out_addr", longint'(out_addr), e.addr);
                        chk(out_len == LW'(e.len), e.req, "out_len", longint'(out_len), e.len);
                        chk(out_last == e.last, e.req, "out_last", longint'(out_last), longint'(e.last));
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic void push_exp(int a, int l, bit last, string req);
        xfer_t e;
        e.addr = a; e.len = l; e.last = last; e.req = req;
        expq.push_back(e);
    endfunction

    // Behavioural reference of the requirements (R2 to R10).
    task automatic model(input int a, input int l, input bit sg, input string req);
        logic [63:0] cnt, claim, diff;
        bit fin;
        int po;
        if (!sg && cq_addr.size() == 0) begin
            push_exp(a, l, 1'b1, req);
            return;
        end
        tot_m = tot_m + 64'(l);
        fin = 1'b0;
        po  = 0;
        if (l >= 8) begin
            cnt = '0;
            for (int k = 0; k < 8; k++) cnt = (cnt << 8) | 64'(mem[a + l - 8 + k]);
            claim = cnt >> 3;
            if (claim <= tot_m) begin
                diff = tot_m - claim;
                if (diff >= 64'd1 && diff <= 64'(l)) begin
                    po  = l - int'(diff);
                    fin = (mem[a + po] == 8'h80);
                end
            end
        end
        if (fin) begin
            tot_m = '0;
            for (int i = 0; i < cq_addr.size(); i++)
                push_exp(cq_addr[i], cq_len[i], (i == cq_addr.size() - 1) && (po == 0), req);
            if (po != 0 || cq_addr.size() == 0) push_exp(a, po, 1'b1, req);
            cq_addr.delete();
            cq_len.delete();
        end else if (sg) begin
            if (cq_addr.size() == DEPTH) begin
                err_exp++;
                cq_addr.delete();
                cq_len.delete();
                tot_m = '0;
            end else begin
                cq_addr.push_back(a);
                cq_len.push_back(l);
            end
        end else begin
            push_exp(a, l, 1'b1, req);
        end
    endtask

    task automatic send(input int a, input int l, input bit sg, input string req);
        model(a, l, sg, req);
        @(negedge clk);
        seg_valid = 1'b1;
        seg_addr  = AW'(a);
        seg_len   = LW'(l);
        seg_sg    = sg;
        while (!seg_ready) @(negedge clk);
        @(negedge clk);
        seg_valid = 1'b0;
    endtask

    task automatic data_seg(input int a, input int l);
        for (int j = 0; j < l; j++) mem[a + j] = 8'h40 | 8'(j % 64);
    endtask

    // Segment with data up to po, marker at po, zeros, and a trailer claiming claim bytes.
    task automatic pad_seg(input int a, input int l, input int po, input longint claim);
        logic [63:0] bits;
        bits = 64'(claim) << 3;
        for (int j = 0; j < l; j++) mem[a + j] = (j < po) ? (8'h40 | 8'(j % 64)) : 8'h00;
        mem[a + po] = 8'h80;
        for (int k = 0; k < 8; k++) mem[a + l - 8 + k] = bits[8*(7-k) +: 8];
    endtask

    task automatic drain(input string req);
        repeat (3) @(negedge clk);
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            if (expq.size() == 0 && seg_ready) break;
        end
        repeat (2) @(negedge clk);
        chk(expq.size() == 0, req, "pending expected outputs", expq.size(), 0);
    endtask

    initial begin
        tot_m = '0;
        for (int i = 0; i < 8192; i++) mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(seg_ready == 1'b1, "R1", "seg_ready", longint'(seg_ready), 1);
        chk(out_valid == 1'b0, "R1", "out_valid", longint'(out_valid), 0);
        chk(rd_req == 1'b0, "R1", "rd_req", longint'(rd_req), 0);
        chk(err == 1'b0, "R1", "err", longint'(err), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R5: lone padded segment trimmed to 20
        pad_seg(32'h100, 64, 20, 20);
        send(32'h100, 64, 1'b1, "R3_R5");
        drain("R5");

        // R2 R7 R11: three-segment message, order and last flag
        data_seg(32'h200, 40);
        data_seg(32'h300, 40);
        pad_seg(32'h400, 48, 20, 100);
        send(32'h200, 40, 1'b1, "R7_R11");
        send(32'h300, 40, 1'b1, "R7_R11");
        send(32'h400, 48, 1'b1, "R2_R11");
        drain("R11");

        // R6: padding-only closing segment drops the empty tail
        data_seg(32'h500, 64);
        pad_seg(32'h600, 64, 0, 64);
        send(32'h500, 64, 1'b1, "R6");
        send(32'h600, 64, 1'b1, "R6");
        drain("R6");

        // R6: empty cache and zero offset gives one empty last segment
        pad_seg(32'h700, 16, 0, 0);
        send(32'h700, 16, 1'b1, "R6");
        drain("R6");

        // R8: direct with empty cache passes untouched and leaves the total alone
        pad_seg(32'h800, 64, 20, 20);
        send(32'h800, 64, 1'b0, "R8");
        pad_seg(32'h900, 64, 20, 20);
        send(32'h900, 64, 1'b1, "R8");
        drain("R8");

        // R9: direct final request combined with the cache
        data_seg(32'hA00, 32);
        pad_seg(32'hB00, 32, 8, 40);
        send(32'hA00, 32, 1'b1, "R9");
        send(32'hB00, 32, 1'b0, "R9");
        drain("R9");

        // R9: direct non-final request released alone, cache kept
        data_seg(32'hC00, 24);
        data_seg(32'hD00, 16);
        pad_seg(32'hE00, 40, 6, 46);
        send(32'hC00, 24, 1'b1, "R9");
        send(32'hD00, 16, 1'b0, "R9");
        send(32'hE00, 40, 1'b1, "R9");
        drain("R9");

        // R4: right trailer but wrong marker byte is not final
        pad_seg(32'hF00, 64, 20, 20);
        mem[32'hF00 + 20] = 8'h00;
        pad_seg(32'h1000, 64, 0, 64);
        send(32'hF00, 64, 1'b1, "R4");
        send(32'h1000, 64, 1'b1, "R4");
        drain("R4");

        // R4: segment shorter than eight bytes is cached
        data_seg(32'h1100, 4);
        pad_seg(32'h1200, 60, 16, 20);
        send(32'h1100, 4, 1'b1, "R4");
        send(32'h1200, 60, 1'b1, "R4");
        drain("R4");

        // R10: overflow after DEPTH cached segments, then a fresh message
        err_seen = 0;
        err_exp  = 0;
        for (int i = 0; i <= DEPTH; i++) begin
            data_seg(32'h1300 + i * 16, 8);
            send(32'h1300 + i * 16, 8, 1'b1, "R10");
        end
        pad_seg(32'h1500, 64, 20, 20);
        send(32'h1500, 64, 1'b1, "R10");
        drain("R10");
        chk(err_seen == err_exp, "R10", "err pulses", err_seen, err_exp);
        chk(err_exp == 1, "R10", "model overflow count", err_exp, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule